// File: doc/BRIEF.md
# Two-Thread Urgency-Driven Switch Controller

This block decides which of two hardware threads owns a coarse-grain multithreaded core. Exactly one thread is in the foreground at any moment. The block holds a small saturating urgency score for each thread. Each score moves in response to per-thread strobes: a last-level cache miss, a last-level cache refill and an asynchronous interrupt. A programmable quantum counter limits how long the foreground thread may keep the core.

A switch happens for one of two reasons. The first is that the quantum runs out. The second is that the foreground thread takes a cache miss that leaves its urgency strictly below the background thread's urgency. On a switch the block raises a one-cycle pipeline flush, flips the foreground thread id and reloads the quantum. A thread that loses the core through quantum expiry gets the top urgency, so that it wins the next miss comparison. An interrupt addressed to the waiting thread raises that thread to the second-highest level.

All outputs are registered. The reset is synchronous and active high.

Top module: `mt_urgency_switch`

## Requirements
- R1: After reset the foreground id is 0, the flush output is 0 and both urgency levels read 5 (each level is 3 bits; thread 0 occupies bits [2:0] of `urg_o` and thread 1 occupies bits [5:3]).
- R2: A miss strobe without a refill strobe for a thread lowers that thread's urgency by one, and a level of 0 stays at 0.
- R3: A refill strobe without a miss strobe raises the thread's urgency by one when the level is below 5, and leaves it unchanged when the level is 5 or more.
- R4: A miss strobe and a refill strobe for the same thread in the same cycle leave that thread's urgency unchanged and do not count as a miss for switching.
- R5: An effective miss on the foreground thread causes a switch only when its updated urgency is strictly lower than the background thread's updated urgency of the same cycle. Equal levels cause no switch.
- R6: An interrupt strobe for the background thread sets that thread's urgency to 6 and overrides its miss and refill strobes of that cycle. An interrupt strobe for the foreground thread has no effect.
- R7: A switch sets `flush_o` to 1 for exactly the cycle in which `fg_o` takes its new value. The foreground id changes at no other time.
- R8: Every switch reloads the quantum counter from the quantum register. With no other switch, the quantum expires and a switch takes effect Q+1 clock edges after the reloading edge, where Q is the reloaded value.
- R9: On a switch caused by quantum expiry, the outgoing thread's urgency becomes 7, whatever its strobes were in that cycle.
- R10: A value written to the quantum register through `qset_we`/`qset_val` takes effect only at the next reload. It does not shorten the quantum that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_i | input | 2 | Per-thread last-level cache miss strobe (bit n = thread n) |
| refill_i | input | 2 | Per-thread last-level cache refill strobe |
| irq_i | input | 2 | Per-thread asynchronous interrupt strobe |
| qset_we | input | 1 | Write enable for the quantum register |
| qset_val | input | QW | New quantum value |
| fg_o | output | 1 | Current foreground thread id |
| flush_o | output | 1 | One-cycle pipeline flush on a switch |
| urg_o | output | 2*3 | Urgency levels, thread 0 in the low field |

## Verification
The hardest case to reach from the ports is a quantum expiry that falls in the same cycle as a foreground miss. Reaching it means knowing the exact edge on which the counter reaches zero, and the power-up quantum is far too long to wait out. The stimulus therefore first writes a short quantum. It then forces a reload with a miss-triggered switch, which also shows that the write alone did not cut the running quantum short. The bench then counts edges to the first expiry, and places a miss strobe on the expiry cycle of the following period. The equal-level comparison and the cancelled miss/refill pair are reached by steering the background level down with misses on the waiting thread, which never cause a switch.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  localparam int NTHR    = 2;
  localparam int URG_W   = 3;
  localparam logic [URG_W-1:0] URG_TOP  = 3'd7;
  localparam logic [URG_W-1:0] URG_INTR = 3'd6;
  localparam logic [URG_W-1:0] URG_CAP  = 3'd5;
  typedef logic [URG_W-1:0] urg_t;
endpackage

// File: rtl/urgency_cell.sv
module urgency_cell
  import mtu_pkg::*;
#(
  parameter urg_t RST_VAL = URG_CAP
) (
  input  logic clk,
  input  logic rst,
  input  logic dec_i,
  input  logic inc_i,
  input  logic set_intr_i,
  input  logic set_top_i,
  output urg_t nxt_o,
  output urg_t cur_o
);
  urg_t lvl_q;
  urg_t lvl_d;

  // Event arithmetic without the expiry preset: this is the value
  // the switch comparison looks at.
  always_comb begin
    lvl_d = lvl_q;
    if (set_intr_i) begin
      lvl_d = URG_INTR;
    end else if (dec_i && !inc_i) begin
      if (lvl_q != '0) lvl_d = lvl_q - 1'b1;
    end else if (inc_i && !dec_i) begin
      if (lvl_q < URG_CAP) lvl_d = lvl_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            lvl_q <= RST_VAL;
    else if (set_top_i) lvl_q <= URG_TOP;
    else                lvl_q <= lvl_d;
  end

  assign nxt_o = lvl_d;
  assign cur_o = lvl_q;
endmodule

// File: rtl/quantum_timer.sv
module quantum_timer #(
  parameter int QW = 8,
  parameter logic [QW-1:0] QRST = 8'd15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [QW-1:0] val_i,
  input  logic          reload_i,
  output logic          expire_o
);
  logic [QW-1:0] period_q;
  logic [QW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= QRST;
      left_q   <= QRST;
    end else begin
      if (wr_i) period_q <= val_i;
      if (reload_i)          left_q <= period_q;
      else if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign expire_o = (left_q == '0);
endmodule

// File: rtl/switch_ctrl.sv
module switch_ctrl
  import mtu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fg_miss_i,
  input  urg_t fg_nxt_i,
  input  urg_t bg_nxt_i,
  input  logic expire_i,
  output logic swap_o,
  output logic fg_o,
  output logic flush_o
);
  logic fg_q;
  logic flush_q;

  assign swap_o = expire_i || (fg_miss_i && (fg_nxt_i < bg_nxt_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      fg_q    <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      fg_q    <= fg_q ^ swap_o;
      flush_q <= swap_o;
    end
  end

  assign fg_o    = fg_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/mt_urgency_switch.sv
module mt_urgency_switch
  import mtu_pkg::*;
#(
  parameter int QW = 8,
  parameter logic [QW-1:0] QUANTUM_RST = 8'd15,
  localparam int UOUT_W = NTHR * URG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NTHR-1:0]   miss_i,
  input  logic [NTHR-1:0]   refill_i,
  input  logic [NTHR-1:0]   irq_i,
  input  logic              qset_we,
  input  logic [QW-1:0]     qset_val,
  output logic              fg_o,
  output logic              flush_o,
  output logic [UOUT_W-1:0] urg_o
);
  urg_t nxt_lvl [NTHR];
  urg_t cur_lvl [NTHR];
  logic expire;
  logic swap;
  logic fg_id;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic is_fg;
    assign is_fg = (fg_id == 1'(t));
    urgency_cell #(.RST_VAL(URG_CAP)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .dec_i      (miss_i[t]),
      .inc_i      (refill_i[t]),
      .set_intr_i (irq_i[t] && !is_fg),
      .set_top_i  (expire && is_fg),
      .nxt_o      (nxt_lvl[t]),
      .cur_o      (cur_lvl[t])
    );
    assign urg_o[t*URG_W +: URG_W] = cur_lvl[t];
  end

  quantum_timer #(.QW(QW), .QRST(QUANTUM_RST)) u_qt (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (qset_we),
    .val_i    (qset_val),
    .reload_i (swap),
    .expire_o (expire)
  );

  switch_ctrl u_sw (
    .clk       (clk),
    .rst       (rst),
    .fg_miss_i (miss_i[fg_id] && !refill_i[fg_id]),
    .fg_nxt_i  (nxt_lvl[fg_id]),
    .bg_nxt_i  (nxt_lvl[!fg_id]),
    .expire_i  (expire),
    .swap_o    (swap),
    .fg_o      (fg_id),
    .flush_o   (flush_o)
  );

  assign fg_o = fg_id;
endmodule

// File: rtl/mtu_checker.sv
module mtu_checker (
  input logic       clk,
  input logic       rst,
  input logic       fg_o,
  input logic       flush_o,
  input logic [5:0] urg_o
);
  logic [3:0] u0, u1;
  assign u0 = {1'b0, urg_o[2:0]};
  assign u1 = {1'b0, urg_o[5:3]};

  // R7
  flush_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (fg_o != $past(fg_o)));
  // R7
  fg_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !flush_o |-> (fg_o == $past(fg_o)));
  // R2
  t0_drop_one_chk: assert property (@(posedge clk) disable iff (rst)
    (u0 + 4'd1) >= $past(u0));
  // R2
  t1_drop_one_chk: assert property (@(posedge clk) disable iff (rst)
    (u1 + 4'd1) >= $past(u1));
  // R3
  t0_jump_preset_chk: assert property (@(posedge clk) disable iff (rst)
    (u0 > $past(u0) + 4'd1) |-> (u0 >= 4'd6));
  // R3
  t1_jump_preset_chk: assert property (@(posedge clk) disable iff (rst)
    (u1 > $past(u1) + 4'd1) |-> (u1 >= 4'd6));
endmodule

bind mt_urgency_switch mtu_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .fg_o    (fg_o),
  .flush_o (flush_o),
  .urg_o   (urg_o)
);

// File: tb/mt_urgency_switch_test.sv
module mt_urgency_switch_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] miss = '0, refill = '0, irq = '0;
  logic       qwe = 1'b0;
  logic [7:0] qval = '0;
  logic       fg, flush;
  logic [5:0] urg;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mt_urgency_switch #(.QW(8), .QUANTUM_RST(8'd200)) uut (
    .clk(clk), .rst(rst), .miss_i(miss), .refill_i(refill), .irq_i(irq),
    .qset_we(qwe), .qset_val(qval), .fg_o(fg), .flush_o(flush), .urg_o(urg)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic state(string req, int f, int fl, int u0, int u1);
    chk({req, " fg"}, fg, f);
    chk({req, " flush"}, flush, fl);
    chk({req, " urg0"}, urg[2:0], u0);
    chk({req, " urg1"}, urg[5:3], u1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; miss = '0; refill = '0; irq = '0; qwe = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic cyc(logic [1:0] m, logic [1:0] r, logic [1:0] i);
    miss = m; refill = r; irq = i;
    @(negedge clk);
    miss = '0; refill = '0; irq = '0;
  endtask

  task automatic t_reset();
    do_reset();
    state("R1 reset", 0, 0, 5, 5);
  endtask

  task automatic t_floor();
    do_reset();
    for (int k = 0; k < 5; k++) cyc(2'b10, 2'b00, 2'b00);
    state("R2 five misses", 0, 0, 5, 0);
    cyc(2'b10, 2'b00, 2'b00);
    state("R2 miss at zero", 0, 0, 5, 0);
  endtask

  task automatic t_cap();
    do_reset();
    cyc(2'b00, 2'b10, 2'b00);
    state("R3 refill at 5", 0, 0, 5, 5);
    for (int k = 0; k < 3; k++) cyc(2'b10, 2'b00, 2'b00);
    cyc(2'b00, 2'b10, 2'b00);
    state("R3 refill 2->3", 0, 0, 5, 3);
    cyc(2'b00, 2'b10, 2'b00);
    cyc(2'b00, 2'b10, 2'b00);
    cyc(2'b00, 2'b10, 2'b00);
    state("R3 climbs to cap", 0, 0, 5, 5);
    cyc(2'b00, 2'b00, 2'b10);
    cyc(2'b00, 2'b10, 2'b00);
    state("R3 refill above cap", 0, 0, 5, 6);
  endtask

  task automatic t_cancel();
    do_reset();
    cyc(2'b10, 2'b00, 2'b00);
    cyc(2'b10, 2'b10, 2'b00);
    state("R4 bg miss+refill", 0, 0, 5, 4);
    cyc(2'b01, 2'b01, 2'b00);
    state("R4 fg miss+refill no switch", 0, 0, 5, 4);
  endtask

  task automatic t_miss_switch();
    do_reset();
    cyc(2'b11, 2'b00, 2'b00);
    state("R5 equal updated levels", 0, 0, 4, 4);
    cyc(2'b01, 2'b00, 2'b00);
    state("R5 lower switches", 1, 1, 3, 4);
    cyc(2'b00, 2'b00, 2'b00);
    state("R7 flush one cycle", 1, 0, 3, 4);
  endtask

  task automatic t_irq();
    do_reset();
    cyc(2'b10, 2'b00, 2'b00);
    cyc(2'b10, 2'b00, 2'b00);
    cyc(2'b01, 2'b00, 2'b00);
    state("R5 4 vs 3 no switch", 0, 0, 4, 3);
    cyc(2'b00, 2'b00, 2'b01);
    state("R6 fg irq ignored", 0, 0, 4, 3);
    cyc(2'b10, 2'b00, 2'b10);
    state("R6 bg irq over miss", 0, 0, 4, 6);
  endtask

  task automatic t_quantum();
    do_reset();
    @(negedge clk); qwe = 1'b1; qval = 8'd3;
    @(negedge clk); qwe = 1'b0;
    state("R10 write no early expiry", 0, 0, 5, 5);
    cyc(2'b01, 2'b00, 2'b00);
    state("R8 miss switch reloads", 1, 1, 4, 5);
    for (int k = 0; k < 3; k++) cyc(2'b00, 2'b00, 2'b00);
    state("R8 before expiry", 1, 0, 4, 5);
    cyc(2'b00, 2'b00, 2'b00);
    state("R9 expiry sets 7", 0, 1, 4, 7);
    cyc(2'b00, 2'b00, 2'b00);
    state("R7 flush drops", 0, 0, 4, 7);
    cyc(2'b00, 2'b00, 2'b00);
    cyc(2'b00, 2'b00, 2'b00);
    cyc(2'b01, 2'b00, 2'b00);
    state("R9 expiry beats miss", 1, 1, 7, 7);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_floor();
    t_cap();
    t_cancel();
    t_miss_switch();
    t_irq();
    t_quantum();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule